// File: doc/BRIEF.md
# Multi-Lane Hit Packet Output Router

This block sits at the end of a pixel readout chain. It takes 48-bit hit packets, at most one per system clock, and deals them out in turn over a set of output lanes. The number of lanes in use can be changed at run time, from one up to the number built in. Each lane keeps its own small packet buffer. It turns each stored packet into six 8-bit symbols, ready for a line encoder further down the path. When a lane has nothing to send, it presents an idle control symbol.

Each lane is paced by its own symbol strobe, which runs at the readout rate. A strobe consumes the symbol now shown on that lane, whether it is a data symbol or the idle code. When any enabled lane is close to full, a single almost-full output tells the upstream source to stop sending packets. The threshold leaves room for one more packet that may already be on its way.

Top module: `hit_lane_router`

## Requirements
- R1: In a cycle with `pkt_valid_i` high, exactly one lane stores the whole packet. A packet is never split over lanes.
- R2: The effective lane count is `lane_cnt_i`, with 0 read as 1 and any value above `NUM_LANES` read as `NUM_LANES`. Packets are written only to lanes with an index below the effective count.
- R3: Packets go to the enabled lanes in rotation, starting at lane 0. After the highest enabled lane, the rotation wraps back to lane 0.
- R4: In a cycle where the effective count differs from the count of the previous cycle, an accepted packet goes to lane 0 and the rotation restarts from there.
- R5: A packet leaves its lane as six data symbols with the control flag low, bits [47:40] first and bits [7:0] last. The six symbols go out on consecutive strobes of that lane, with no idle symbol between them.
- R6: A lane with no stored packet shows symbol 0xBC with the control flag high. A strobe on such a lane consumes one idle slot and does not change the lane's state.
- R7: A lane's symbol and control flag change only after a strobe on that lane. The one exception is an empty lane, which may switch from idle to a newly written packet.
- R8: Each lane holds `DEPTH` waiting packets (4 by default) plus the packet it is currently sending. Packets leave a lane in the order in which they arrived.
- R9: `almost_full_o` is high in exactly those cycles where some enabled lane has at least `DEPTH-1` waiting packets. The packet currently being sent is not counted.
- R10: After reset, every lane shows idle, `almost_full_o` is low, and the rotation starts at lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | A packet is offered this cycle |
| pkt_data_i | input | 48 | Packet contents |
| lane_cnt_i | input | $clog2(NUM_LANES+1) | Number of lanes in use |
| sym_req_i | input | NUM_LANES | Per-lane strobe that consumes the shown symbol |
| sym_o | output | NUM_LANES*8 | Symbol of each lane; lane n uses bits [8n+7:8n] |
| sym_ctrl_o | output | NUM_LANES | High when the lane's symbol is a control code |
| almost_full_o | output | 1 | Upstream must stop offering packets |

## Verification
In a single cycle, a lane's buffer can receive a packet while the lane's strobe removes its head entry. That head entry may be the first symbol of the next packet, or an idle slot on an empty lane. Random strobe patterns are run against a packet source that reacts to almost-full one cycle late, so buffers sit near full while both push and pop happen in the same cycle. A queue model in the bench predicts every lane symbol, every control flag and the almost-full level, and compares them on every clock. Directed sequences also pin down the rotation restart on a count change and the exact cycle in which almost-full falls.

// File: rtl/hit_router_pkg.sv
package hit_router_pkg;
  localparam int SYM_W        = 8;
  localparam int PKT_W        = 48;
  localparam int SYMS_PER_PKT = PKT_W / SYM_W;
  localparam logic [SYM_W-1:0] K_IDLE = 8'hBC;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [PKT_W-1:0] pkt_t;
endpackage

// File: rtl/lane_rr_sel.sv
module lane_rr_sel #(
  parameter  int NUM_LANES = 8,
  localparam int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int CNT_W     = $clog2(NUM_LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              accept_i,
  output logic [LANE_W-1:0] sel_o,
  output logic [CNT_W-1:0]  eff_cnt_o
);
  logic [CNT_W-1:0]  eff, prev_q, sel_inc;
  logic [LANE_W-1:0] ptr_q, nxt;
  logic              changed;

  always_comb begin
    if (cnt_i == '0)                        eff = CNT_W'(1);
    else if (cnt_i > CNT_W'(NUM_LANES))     eff = CNT_W'(NUM_LANES);
    else                                    eff = cnt_i;
    changed = (eff != prev_q);
    sel_o   = changed ? '0 : ptr_q;
    sel_inc = CNT_W'(sel_o) + CNT_W'(1);
    nxt     = (sel_inc >= eff) ? '0 : LANE_W'(sel_inc);
  end

  assign eff_cnt_o = eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      prev_q <= CNT_W'(1);
    end else begin
      prev_q <= eff;
      if (accept_i)     ptr_q <= nxt;
      else if (changed) ptr_q <= '0;
    end
  end

  // pointer always names a lane that was enabled last cycle
  assert_ptr_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(ptr_q) < prev_q);

  // after a count change with an accept, rotation continues from lane 0
  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && changed && eff > CNT_W'(1)) |=> ptr_q == LANE_W'(1));
endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter  int WIDTH = 48,
  parameter  int DEPTH = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             full, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full);

  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/lane_serializer.sv
module lane_serializer
  import hit_router_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  pkt_t head_i,
  input  logic avail_i,
  input  logic req_i,
  output logic pop_o,
  output sym_t sym_o,
  output logic ctrl_o
);
  localparam int IW = $clog2(SYMS_PER_PKT);
  localparam logic [IW-1:0] LAST = IW'(SYMS_PER_PKT - 1);

  pkt_t          pkt_q;
  logic [IW-1:0] idx_q;
  logic          busy_q;

  function automatic sym_t pick(pkt_t p, logic [IW-1:0] i);
    return p[PKT_W - 1 - SYM_W * int'(i) -: SYM_W];
  endfunction

  // head of buffer is shown directly, so the first symbol costs no extra slot
  always_comb begin
    if (busy_q) begin
      sym_o  = pick(pkt_q, idx_q);
      ctrl_o = 1'b0;
    end else if (avail_i) begin
      sym_o  = pick(head_i, '0);
      ctrl_o = 1'b0;
    end else begin
      sym_o  = K_IDLE;
      ctrl_o = 1'b1;
    end
  end

  assign pop_o = req_i && !busy_q && avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (pop_o) begin
      pkt_q  <= head_i;
      idx_q  <= IW'(1);
      busy_q <= 1'b1;
    end else if (req_i && busy_q) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + IW'(1);
    end
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((busy_q || avail_i) && !req_i) |=> ($stable(sym_o) && $stable(ctrl_o)));

  assert_no_idle_inside_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !ctrl_o);

  assert_msb_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> (sym_o == $past(head_i[PKT_W-1-SYM_W -: SYM_W])));
endmodule

// File: rtl/hit_lane_router.sv
module hit_lane_router
  import hit_router_pkg::*;
#(
  parameter  int NUM_LANES = 8,
  parameter  int DEPTH     = 4,
  localparam int CNT_W     = $clog2(NUM_LANES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pkt_valid_i,
  input  logic [PKT_W-1:0]           pkt_data_i,
  input  logic [CNT_W-1:0]           lane_cnt_i,
  input  logic [NUM_LANES-1:0]       sym_req_i,
  output logic [NUM_LANES*SYM_W-1:0] sym_o,
  output logic [NUM_LANES-1:0]       sym_ctrl_o,
  output logic                       almost_full_o
);
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int FCW    = $clog2(DEPTH + 1);

  logic [LANE_W-1:0]    sel;
  logic [CNT_W-1:0]     eff_cnt;
  logic [NUM_LANES-1:0] push, near;

  lane_rr_sel #(.NUM_LANES(NUM_LANES)) i_rr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (lane_cnt_i),
    .accept_i  (pkt_valid_i),
    .sel_o     (sel),
    .eff_cnt_o (eff_cnt)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    pkt_t           head;
    logic           empty, pop;
    logic [FCW-1:0] fill;

    assign push[l] = pkt_valid_i && (sel == LANE_W'(l));

    pkt_fifo #(.WIDTH(PKT_W), .DEPTH(DEPTH)) i_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[l]),
      .wdata_i (pkt_data_i),
      .pop_i   (pop),
      .rdata_o (head),
      .empty_o (empty),
      .count_o (fill)
    );

    lane_serializer i_ser (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .head_i  (head),
      .avail_i (!empty),
      .req_i   (sym_req_i[l]),
      .pop_o   (pop),
      .sym_o   (sym_o[l*SYM_W +: SYM_W]),
      .ctrl_o  (sym_ctrl_o[l])
    );

    // one free entry left covers a packet already in flight
    assign near[l] = (CNT_W'(l) < eff_cnt) && (fill >= FCW'(DEPTH - 1));
  end

  assign almost_full_o = |near;

  assert_single_lane_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |-> ($countones(push) == 1));

  assert_idle_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |-> $onehot0(push) && (push == '0));

  assert_enabled_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |-> (CNT_W'(sel) < eff_cnt));

  assert_af_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(almost_full_o) |-> ($past(pkt_valid_i) || ($past(lane_cnt_i) != lane_cnt_i)));
endmodule

// File: tb/test_hit_lane_router.sv
`timescale 1ns/1ps
module test_hit_lane_router;
  localparam int NL    = 8;
  localparam int DEPTH = 4;
  localparam int CW    = $clog2(NL + 1);

  typedef logic [7:0] byteq_t [$];

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            pkt_valid = 1'b0;
  logic [47:0]     pkt_data = '0;
  logic [CW-1:0]   lane_cnt = CW'(8);
  logic [NL-1:0]   sym_req = '0;
  logic [NL*8-1:0] sym;
  logic [NL-1:0]   sym_ctrl;
  logic            almost_full;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  byteq_t mq [NL];
  int     m_ptr  = 0;
  int     m_prev = 1;

  always #2 clk = ~clk;

  hit_lane_router #(.NUM_LANES(NL), .DEPTH(DEPTH)) i_hit_lane_router (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .pkt_valid_i   (pkt_valid),
    .pkt_data_i    (pkt_data),
    .lane_cnt_i    (lane_cnt),
    .sym_req_i     (sym_req),
    .sym_o         (sym),
    .sym_ctrl_o    (sym_ctrl),
    .almost_full_o (almost_full)
  );

  function automatic int clamp_cnt(int c);
    if (c == 0) return 1;
    if (c > NL) return NL;
    return c;
  endfunction

  function automatic logic [7:0] byte_of(logic [47:0] p, int i);
    return p[47 - 8*i -: 8];
  endfunction

  task automatic check(string tag, string what, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // reference model: one symbol queue per lane
  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int l = 0; l < NL; l++) mq[l].delete();
      m_ptr  = 0;
      m_prev = 1;
    end else begin
      int eff;
      int sel;
      bit chg;
      eff = clamp_cnt(int'(lane_cnt));
      chg = (eff != m_prev);
      sel = chg ? 0 : m_ptr;
      for (int l = 0; l < NL; l++)
        if (sym_req[l] && mq[l].size() > 0) void'(mq[l].pop_front());
      if (pkt_valid) begin
        for (int s = 0; s < 6; s++) mq[sel].push_back(byte_of(pkt_data, s));
        m_ptr = (sel + 1 >= eff) ? 0 : sel + 1;
      end else if (chg) begin
        m_ptr = 0;
      end
      m_prev = eff;
    end
  end

  // compare every lane and almost-full against the model on each cycle
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int eff;
      bit exp_af;
      eff    = clamp_cnt(int'(lane_cnt));
      exp_af = 1'b0;
      for (int l = 0; l < NL; l++) begin
        if (mq[l].size() > 0) begin
          check("R5", $sformatf("lane %0d data", l),
                {23'd0, sym_ctrl[l], sym[l*8 +: 8]}, {23'd0, 1'b0, mq[l][0]});
        end else begin
          check("R6", $sformatf("lane %0d idle", l),
                {23'd0, sym_ctrl[l], sym[l*8 +: 8]}, {23'd0, 1'b1, 8'hBC});
        end
        if (l < eff && (mq[l].size() / 6) >= DEPTH - 1) exp_af = 1'b1;
        if ((mq[l].size() + 5) / 6 > DEPTH + 1) check("R8", "lane capacity", 1, 0);
      end
      check("R9", "almost_full", almost_full, exp_af);
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] pa [8];
    logic [47:0] pb [5];
    logic [47:0] pc [4];
    logic [47:0] exp_p;
    int cnt_list [6];
    bit af_prev;
    bit af_now;

    cnt_list = '{5, 0, 8, 2, 12, 3};
    for (int i = 0; i < 8; i++) pa[i] = {8'hA0 + 8'(i), 40'h1122334455 + 40'(i)};
    for (int i = 0; i < 5; i++) pb[i] = {8'hB0 + 8'(i), 40'h6677889900 + 40'(i * 3)};
    for (int i = 0; i < 4; i++) pc[i] = {8'hC0 + 8'(i), 40'hDEADBEEF00 + 40'(i * 7)};

    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R10: reset state
    for (int l = 0; l < NL; l++)
      check("R10", $sformatf("lane %0d after reset", l),
            {23'd0, sym_ctrl[l], sym[l*8 +: 8]}, {23'd0, 1'b1, 8'hBC});
    check("R10", "almost_full after reset", almost_full, 0);

    // R1, R3: eight lanes, one packet each, rotation from lane 0
    for (int i = 0; i < 8; i++) begin
      pkt_valid = 1'b1;
      pkt_data  = pa[i];
      tick();
    end
    pkt_valid = 1'b0;
    for (int l = 0; l < NL; l++)
      check("R1", $sformatf("lane %0d head", l), sym[l*8 +: 8], byte_of(pa[l], 0));
    for (int s = 0; s < 6; s++) begin
      for (int l = 0; l < NL; l++)
        check("R5", $sformatf("lane %0d symbol %0d", l, s),
              {23'd0, sym_ctrl[l], sym[l*8 +: 8]}, {23'd0, 1'b0, byte_of(pa[l], s)});
      sym_req = '1;
      tick();
    end
    sym_req = '0;
    for (int l = 0; l < NL; l++)
      check("R6", $sformatf("lane %0d idle after drain", l),
            {23'd0, sym_ctrl[l], sym[l*8 +: 8]}, {23'd0, 1'b1, 8'hBC});

    // R2, R3: three lanes, wrap back to lane 0
    lane_cnt = CW'(3);
    for (int i = 0; i < 4; i++) begin
      pkt_valid = 1'b1;
      pkt_data  = pb[i];
      tick();
    end
    pkt_valid = 1'b0;
    check("R3", "lane 0 head", sym[0 +: 8], byte_of(pb[0], 0));
    check("R3", "lane 1 head", sym[8 +: 8], byte_of(pb[1], 0));
    check("R3", "lane 2 head", sym[16 +: 8], byte_of(pb[2], 0));
    for (int l = 3; l < NL; l++)
      check("R2", $sformatf("disabled lane %0d", l), sym_ctrl[l], 1);
    repeat (3) tick();
    check("R7", "lane 0 held without strobe", sym[0 +: 8], byte_of(pb[0], 0));

    // R4: count change sends the next packet to lane 0, not lane 1
    lane_cnt  = CW'(2);
    pkt_valid = 1'b1;
    pkt_data  = pb[4];
    tick();
    pkt_valid = 1'b0;
    check("R4", "lane 1 untouched", sym[8 +: 8], byte_of(pb[1], 0));
    for (int j = 0; j < 18; j++) begin
      exp_p = (j < 6) ? pb[0] : (j < 12) ? pb[3] : pb[4];
      check((j < 6) ? "R5" : (j < 12) ? "R8" : "R4", $sformatf("lane 0 symbol %0d", j),
            sym[0 +: 8], byte_of(exp_p, j % 6));
      sym_req = NL'(1);
      tick();
    end
    sym_req = '1;
    repeat (6) tick();
    sym_req = '0;

    // R9, R8: one lane fills up, almost-full threshold and drain order
    lane_cnt = CW'(1);
    for (int i = 0; i < 4; i++) begin
      pkt_valid = 1'b1;
      pkt_data  = pc[i];
      tick();
      pkt_valid = 1'b0;
      check("R9", $sformatf("almost_full after %0d packets", i + 1), almost_full, (i >= 2) ? 1 : 0);
    end
    for (int j = 0; j < 24; j++) begin
      check("R8", $sformatf("lane 0 drain symbol %0d", j), sym[0 +: 8], byte_of(pc[j / 6], j % 6));
      if (j == 1) check("R9", "almost_full with three waiting", almost_full, 1);
      if (j == 7) check("R9", "almost_full with two waiting", almost_full, 0);
      sym_req = NL'(1);
      tick();
    end
    sym_req = '0;

    // random traffic, upstream reacts to almost-full one cycle late
    foreach (cnt_list[k]) begin
      lane_cnt = CW'(cnt_list[k]);
      af_prev  = 1'b0;
      for (int n = 0; n < 3000; n++) begin
        af_now    = almost_full;
        pkt_valid = ($urandom_range(99) < 60) && !af_prev;
        pkt_data  = {$urandom(), $urandom()};
        sym_req   = NL'($urandom());
        af_prev   = af_now;
        tick();
      end
      pkt_valid = 1'b0;
      sym_req   = '1;
      repeat (40) tick();
      sym_req   = '0;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule